// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Controller

This block is a byte-wide static RAM with a second, nonvolatile-style copy of every location standing behind it. Software-visible traffic goes to the working array through active-low chip-enable, output-enable and write-enable strobes, with the data bus split into an input, an output and an output-enable. A behind-the-scenes shadow array keeps a saved image. STORE copies the working array into the shadow. RECALL copies the shadow back into the working array.

A STORE has two possible triggers. One is a rising edge on the power-fail input from an external comparator, called an automatic store. The other is a falling edge on the shared open-drain busy line, called an external store. In either case the STORE only runs if at least one write has completed since the last transfer. While a STORE or RECALL is running, every read and write is ignored. During an automatic store the block pulls the busy line low. After reset the block performs one RECALL before it serves any access.

The copy walks one address per clock. A STORE is padded to a parameterised number of cycles that stands in for the multi-millisecond save time.

Top module: `shsram_ctrl`

## Requirements
- R1: When `ce_n`=0, `oe_n`=0, `we_n`=1, `busy_in_n`=1 and no transfer is running, `dq_oe`=1 and `dq_out` shows the working byte at `addr`. In every other case `dq_oe`=0.
- R2: A write cycle is active while `ce_n`=0, `we_n`=0, `busy_in_n`=1 and no transfer runs. The working byte changes only when the cycle ends (`ce_n` or `we_n` returns high). It takes the address and data sampled in the last active clock.
- R3: `dq_oe` is 0 whenever `we_n` is 0, even with `oe_n` low.
- R4: After reset is released, a RECALL runs for DEPTH (2048) cycles. During it reads give `dq_oe`=0 and writes are ignored. Afterwards every working byte equals its shadow byte.
- R5: A rising edge on `pfail`, or a falling edge on `busy_in_n`, starts a STORE if the dirty condition holds. The STORE copies every working byte into the shadow, and a later RECALL brings those values back.
- R6: A STORE request with no completed write since the last STORE or RECALL is discarded. `busy_out_n` stays 1 and reads work on the next cycle.
- R7: The dirty condition is cleared at the end of every STORE and RECALL, so a second request with no new write is discarded.
- R8: A store request that arrives while a transfer runs is dropped, not queued.
- R9: During an automatic store `busy_out_n` is 0 for exactly STORE_TICKS cycles (default 2560). During an external store it stays 1.
- R10: Reads and writes attempted during a STORE have no effect on the working array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 11 | Byte address |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Read data |
| dq_oe | output | 1 | Drive enable for the data bus |
| pfail | input | 1 | Power-fail indication, rising edge requests a store |
| busy_in_n | input | 1 | Sensed level of the shared busy line |
| busy_out_n | output | 1 | Pull-low drive for the busy line (0 = drive low) |

## Verification
A stale or wrong dirty flag shows within a few cycles of a store request. Either `busy_out_n` falls when it should not, or it stays high when it should fall. A counter that is off by one gives an automatic-store low window of the wrong length. A copy loop that skips or misaddresses a location only shows after a later reset, when the recalled bytes are read back through the normal read path. Lockout faults show at once as `dq_oe` asserting during a transfer, or as a byte corrupted by a write attempted during a store.

// File: rtl/shsram_pkg.sv
package shsram_pkg;
    typedef enum logic [1:0] {
        XF_IDLE   = 2'd0,
        XF_RECALL = 2'd1,
        XF_STORE  = 2'd2
    } xfer_e;
endpackage

// File: rtl/shsram_array.sv
module shsram_array #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/shsram_decode.sv
module shsram_decode #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          busy_in_n,
    input  logic          idle,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          rd_en,
    output logic          commit,
    output logic [AW-1:0] c_addr,
    output logic [DW-1:0] c_data
);
    typedef struct packed {
        logic          pend;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } dec_s;

    dec_s r_d, r_q;
    logic wr_act;

    always_comb begin
        r_d    = r_q;
        wr_act = !ce_n && !we_n && busy_in_n && idle;
        rd_en  = !ce_n && !oe_n && we_n && busy_in_n && idle;
        commit = 1'b0;
        if (wr_act) begin
            r_d.pend = 1'b1;
            r_d.addr = addr;
            r_d.data = din;
        end else if (r_q.pend) begin
            commit   = idle;
            r_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign c_addr = r_q.addr;
    assign c_data = r_q.data;

    AST_NO_COMMIT_MIDWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (ce_n || we_n || !busy_in_n)); // R2
endmodule

// File: rtl/shsram_seq.sv
module shsram_seq
    import shsram_pkg::*;
#(
    parameter int AW    = 11,
    parameter int TICKS = 2560,
    parameter int CW    = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pfail,
    input  logic          busy_in_n,
    input  logic          commit,
    output xfer_e         state,
    output logic [CW-1:0] cnt,
    output logic          auto_st
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        xfer_e         st;
        logic [CW-1:0] cnt;
        logic          dirty;
        logic          pf;
        logic          bz;
        logic          auto_st;
    } seq_s;

    seq_s s_d, s_q;
    logic pf_req, bz_req, last;

    always_comb begin
        s_d    = s_q;
        s_d.pf = pfail;
        s_d.bz = busy_in_n;
        pf_req = pfail && !s_q.pf;
        bz_req = !busy_in_n && s_q.bz;
        last   = 1'b0;
        case (s_q.st)
            XF_IDLE: begin
                s_d.dirty = s_q.dirty || commit;
                if ((pf_req || bz_req) && (s_q.dirty || commit)) begin
                    s_d.st      = XF_STORE;
                    s_d.cnt     = '0;
                    s_d.auto_st = pf_req;
                end
            end
            XF_RECALL: begin
                last    = (s_q.cnt == CW'(DEPTH - 1));
                s_d.cnt = s_q.cnt + 1'b1;
            end
            default: begin
                last    = (s_q.cnt == CW'(TICKS - 1));
                s_d.cnt = s_q.cnt + 1'b1;
            end
        endcase
        if (last) begin
            s_d.st      = XF_IDLE;
            s_d.cnt     = '0;
            s_d.dirty   = 1'b0;
            s_d.auto_st = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.st      <= XF_RECALL;
            s_q.bz      <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign state   = s_q.st;
    assign cnt     = s_q.cnt;
    assign auto_st = s_q.auto_st;

    AST_STORE_NEEDS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == XF_STORE && $past(s_q.st) == XF_IDLE) |-> $past(s_q.dirty || commit)); // R6
    AST_DIRTY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == XF_IDLE && $past(s_q.st) != XF_IDLE) |-> !s_q.dirty); // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < CW'(TICKS)); // R9
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == XF_STORE && s_q.cnt != '0) |=> (s_q.st == XF_IDLE || s_q.cnt == $past(s_q.cnt) + 1'b1)); // R8
endmodule

// File: rtl/shsram_ctrl.sv
module shsram_ctrl
    import shsram_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int STORE_TICKS = 2560
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic              pfail,
    input  logic              busy_in_n,
    output logic              busy_out_n
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int TICKS = (STORE_TICKS < DEPTH) ? DEPTH : STORE_TICKS;
    localparam int CW    = $clog2(TICKS) + 1;

    xfer_e              state;
    logic [CW-1:0]      cnt;
    logic               auto_st, idle, commit;
    logic [ADDR_W-1:0]  c_addr, copy_addr, w_raddr, w_waddr;
    logic [DATA_W-1:0]  c_data, w_rdata, s_rdata, w_wdata;
    logic               w_we, s_we;

    assign idle      = (state == XF_IDLE);
    assign copy_addr = cnt[ADDR_W-1:0];

    shsram_decode #(.AW(ADDR_W), .DW(DATA_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .busy_in_n(busy_in_n), .idle(idle), .addr(addr), .din(dq_in),
        .rd_en(dq_oe), .commit(commit), .c_addr(c_addr), .c_data(c_data)
    );

    shsram_seq #(.AW(ADDR_W), .TICKS(TICKS), .CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .pfail(pfail), .busy_in_n(busy_in_n),
        .commit(commit), .state(state), .cnt(cnt), .auto_st(auto_st)
    );

    always_comb begin
        if (state == XF_RECALL) begin
            w_we    = 1'b1;
            w_waddr = copy_addr;
            w_wdata = s_rdata;
        end else begin
            w_we    = commit;
            w_waddr = c_addr;
            w_wdata = c_data;
        end
        w_raddr = idle ? addr : copy_addr;
        s_we    = (state == XF_STORE) && (cnt[CW-1:ADDR_W] == '0);
    end

    shsram_array #(.AW(ADDR_W), .DW(DATA_W)) u_work (
        .clk(clk), .we(w_we), .waddr(w_waddr), .wdata(w_wdata),
        .raddr(w_raddr), .rdata(w_rdata)
    );

    shsram_array #(.AW(ADDR_W), .DW(DATA_W)) u_shadow (
        .clk(clk), .we(s_we), .waddr(copy_addr), .wdata(w_rdata),
        .raddr(copy_addr), .rdata(s_rdata)
    );

    assign dq_out     = w_rdata;
    assign busy_out_n = !(state == XF_STORE && auto_st);

    AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dq_oe && !we_n)); // R3
    AST_NO_WORK_WRITE_IN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == XF_STORE) |-> !w_we); // R10
    AST_NO_READ_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (state != XF_IDLE) |-> !dq_oe); // R4
    AST_BUSY_ONLY_IN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_out_n |-> (state == XF_STORE)); // R9
endmodule

// File: tb/tb_shsram_ctrl.sv
module tb_shsram_ctrl;
    localparam int AW = 11, DW = 8, DEPTH = 1 << AW, TICKS = 2560;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce_n = 1, oe_n = 1, we_n = 1, pfail = 0, ext_n = 1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0, dq_out;
    logic dq_oe, busy_out_n, busy_line;

    assign busy_line = ext_n & busy_out_n;

    shsram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .STORE_TICKS(TICKS)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .pfail(pfail), .busy_in_n(busy_line), .busy_out_n(busy_out_n)
    );

    always #4 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;
    logic [DW-1:0] w_m [DEPTH];
    logic [DW-1:0] s_m [DEPTH];
    bit wk [DEPTH];
    bit sk [DEPTH];

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_byte(int a);
        return w_m[a];
    endfunction

    task automatic idle_bus();
        ce_n = 1; oe_n = 1; we_n = 1;
    endtask

    task automatic wr(int a, logic [DW-1:0] d);
        @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr = AW'(a); dq_in = d;
        @(negedge clk); idle_bus();
        w_m[a] = d; wk[a] = 1;
    endtask

    task automatic rd(int a, string req);
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = AW'(a);
        #1;
        check(req, {31'd0, dq_oe}, 32'd1);
        if (wk[a]) check(req, {24'd0, dq_out}, {24'd0, exp_byte(a)});
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; idle_bus();
        repeat (3) @(negedge clk);
        check("R4 reset busy", {31'd0, busy_out_n}, 32'd1);
        check("R4 reset oe", {31'd0, dq_oe}, 32'd0);
        rst_n = 1;
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = 11'd7; #1;
        check("R4 read during recall", {31'd0, dq_oe}, 32'd0);
        @(negedge clk); ce_n = 0; oe_n = 1; we_n = 0; dq_in = 8'hEE;
        @(negedge clk); idle_bus();
        repeat (DEPTH + 4) @(negedge clk);
        for (int i = 0; i < DEPTH; i++) begin w_m[i] = s_m[i]; wk[i] = sk[i]; end
    endtask

    task automatic pulse_pfail_expect_none(string req);
        @(negedge clk); pfail = 1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (busy_out_n !== 1'b1) check(req, {31'd0, busy_out_n}, 32'd1);
        end
        check(req, {31'd0, busy_out_n}, 32'd1);
        pfail = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1; total++; bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) begin wk[i] = 0; sk[i] = 0; end
        do_reset();

        // R6: no write since recall, request discarded, read usable at once
        pulse_pfail_expect_none("R6 clean pfail");
        wr(3, 8'h5A);
        rd(3, "R1 readback");

        // R2: data sampled in last active cycle
        @(negedge clk); ce_n = 0; we_n = 0; oe_n = 0; addr = 11'd9; dq_in = 8'h11; #1;
        check("R3 oe off during write", {31'd0, dq_oe}, 32'd0);
        @(negedge clk); dq_in = 8'h22;
        @(negedge clk); idle_bus();
        w_m[9] = 8'h22; wk[9] = 1;
        rd(9, "R2 last data");

        // random traffic
        for (int k = 0; k < 500; k++) begin
            int a = ($urandom % 4 == 0) ? int'($urandom % DEPTH) : int'($urandom % 64);
            if ($urandom % 2) wr(a, DW'($urandom));
            else rd(a, "R1 random read");
        end
        @(negedge clk); ce_n = 1; oe_n = 0; we_n = 1; #1;
        check("R1 no oe when deselected", {31'd0, dq_oe}, 32'd0);

        wr(0, 8'hA0);
        wr(DEPTH - 1, 8'hF7);

        // R5/R9: automatic store, with R8/R10 stimulus inside
        @(negedge clk); idle_bus(); pfail = 1;
        n = 0;
        forever begin
            @(negedge clk);
            if (busy_out_n === 1'b0) n++;
            else if (n > 0) break;
            if (n == 10) pfail = 0;
            if (n == 20) pfail = 1;
            if (n == 30) ext_n = 0;
            if (n == 35) ext_n = 1;
            if (n == 50) begin ce_n = 0; we_n = 0; addr = '0; dq_in = 8'h33; end
            if (n == 53) idle_bus();
            if (n == 60) begin ce_n = 0; oe_n = 0; we_n = 1; #1;
                check("R10 read blocked in store", {31'd0, dq_oe}, 32'd0); end
            if (n == 62) idle_bus();
            if (n > TICKS + 50) break;
        end
        pfail = 0; idle_bus();
        check("R9 auto store length", n, TICKS);
        for (int i = 0; i < DEPTH; i++) begin s_m[i] = w_m[i]; sk[i] = wk[i]; end
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (busy_out_n !== 1'b1) check("R8 no queued store", {31'd0, busy_out_n}, 32'd1);
        end
        check("R8 no queued store", {31'd0, busy_out_n}, 32'd1);
        rd(0, "R10 write ignored in store");

        // R7: dirty cleared
        pulse_pfail_expect_none("R7 clean after store");

        // R5: external store
        wr(0, 8'hC3);
        wr(100, 8'h4D);
        @(negedge clk); ext_n = 0;
        for (int i = 0; i < TICKS + 10; i++) begin
            @(negedge clk);
            if (busy_out_n !== 1'b1) begin
                check("R9 ext store no drive", {31'd0, busy_out_n}, 32'd1);
                break;
            end
        end
        ext_n = 1;
        @(negedge clk);
        for (int i = 0; i < DEPTH; i++) begin s_m[i] = w_m[i]; sk[i] = wk[i]; end
        wr(0, 8'h99);
        wr(100, 8'h98);

        // R4/R5: reset recalls saved image
        do_reset();
        rd(0, "R5 recalled byte 0");
        rd(100, "R5 recalled byte 100");
        rd(DEPTH - 1, "R5 recalled top byte");
        rd(7, "R4 write ignored in recall");
        rd(9, "R4 recalled byte 9");
        pulse_pfail_expect_none("R7 clean after recall");

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule